// File: doc/BRIEF.md
# AXI-Lite Write Joiner

This block is the write half of a memory-backed AXI-Lite target. The write-address and write-data channels are handled apart from each other, so either one may deliver its beat before the other. Each channel has a one-entry holding slot. The slot lets the block keep its ready output registered and still take one beat per clock. When an address and a data beat are both available, and the write response channel is free to take a new response, the block issues one byte-masked write to the memory write port. It then raises the write response.

The block's ready outputs act as the "slot empty" flags. A channel that has delivered its half of a write stays stalled until the other half arrives. A channel that accepts a beat while the response channel is blocked also stalls until the response moves. Under full streaming with the response channel always ready, one write completes on every clock.

Top module: `lw_write_joiner`

## Requirements
- R1: While reset is high, and on the first clock after it falls, `s_awready` and `s_wready` are 1, and `s_bvalid` and `mem_we` are 0.
- R2: A write is issued only when three things hold: an address is present (incoming or held), a data beat is present (incoming or held), and the response channel is not blocked (`s_bvalid` high with `s_bready` low). When a write is issued, `mem_we` is high on the next clock.
- R3: Writes are issued in acceptance order. The k-th accepted address pairs with the k-th accepted data beat. `mem_addr`, `mem_data` and `mem_be` carry exactly those values.
- R4: `mem_be` bit i enables byte lane i (bits 8i+7 down to 8i) of the 32-bit word. Lanes whose bit is 0 keep their earlier contents.
- R5: `s_bvalid` rises on the clock after a write is issued, whatever the state of `s_bready`. Once high, it stays high until a clock on which `s_bready` is high.
- R6: `s_bresp` is always 2'b00 (OKAY).
- R7: If a channel holds or accepts a beat on a clock where no write is issued, its ready is 0 on the next clock. This includes the case where it accepts a beat while the response channel is blocked.
- R8: A channel's ready is 1 on the clock after a write is issued. It is also 1 on the clock after a clock on which the channel neither held nor received a beat.
- R9: A beat that arrives without its partner is held. Its channel's ready stays 0 and no write is issued until the partner arrives. The write then happens from the held value.
- R10: Both slots are never full at once while `s_bvalid` is 0.
- R11: With `s_bready` held high and both channels valid on every clock, one write is issued per clock.
- R12: No beat is lost or duplicated. The number of write-response handshakes and memory writes equals the number of address/data pairs sent, and the final memory contents match a reference model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready (low = address slot full) |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready (low = data slot full) |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte lane enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write byte address |
| mem_data | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |

## Verification
The bench builds the block with `ADDR_W` = 6, so the memory has 16 words. Random addresses therefore land on the same words many times, and overlapping partial strobes must merge correctly against the reference model. The short address also keeps the final full-memory comparison cheap. That comparison covers every word after hundreds of skewed, back-pressured writes, alongside directed address-first, data-first, blocked-response and full-rate streaming cases.

// File: rtl/lw_pkg.sv
package lw_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [STRB_W-1:0] strb_t;

    typedef struct packed {
        word_t data;
        strb_t strb;
    } wbeat_t;

    localparam int BEAT_W = $bits(wbeat_t);

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } resp_e;

endpackage

// File: rtl/lw_hold_slot.sv
module lw_hold_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_payload,
    input  logic         fire,
    output logic         ready,
    output logic         have,
    output logic [W-1:0] payload
);

    logic         ready_q;
    logic [W-1:0] held_q;

    // ready low means the slot holds a beat
    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b1;
        else     ready_q <= !have || fire;
    end

    // capture whenever empty; contents are don't-care unless a beat was taken
    always_ff @(posedge clk) begin
        if (ready_q) held_q <= in_payload;
    end

    assign have    = in_valid || !ready_q;
    assign payload = ready_q ? in_payload : held_q;
    assign ready   = ready_q;

    // R7
    hold_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (have && !fire) |=> !ready);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (fire || !have) |=> ready);

endmodule

// File: rtl/lw_join_ctrl.sv
module lw_join_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic aw_have,
    input  logic w_have,
    input  logic b_ready,
    output logic fire,
    output logic b_valid
);

    logic b_valid_q;
    logic b_stall;

    assign b_stall = b_valid_q && !b_ready;
    assign fire    = aw_have && w_have && !b_stall;

    always_ff @(posedge clk) begin
        if (rst) b_valid_q <= 1'b0;
        else     b_valid_q <= fire || b_stall;
    end

    assign b_valid = b_valid_q;

    // R5
    resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (b_valid && !b_ready) |=> b_valid);

    // R5
    resp_set_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> b_valid);

endmodule

// File: rtl/lw_mem_port.sv
module lw_mem_port
    import lw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr,
    input  wbeat_t            beat,
    output logic              we,
    output logic [ADDR_W-1:0] addr_q,
    output word_t             data_q,
    output strb_t             be_q
);

    always_ff @(posedge clk) begin
        if (rst) we <= 1'b0;
        else     we <= fire;
    end

    always_ff @(posedge clk) begin
        if (fire) begin
            addr_q <= addr;
            data_q <= beat.data;
            be_q   <= beat.strb;
        end
    end

endmodule

// File: rtl/lw_write_joiner.sv
module lw_write_joiner
    import lw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data,
    output logic [3:0]        mem_be
);

    logic              aw_have, w_have, fire;
    logic [ADDR_W-1:0] addr_sel;
    logic [BEAT_W-1:0] beat_sel;
    wbeat_t            beat_in;

    assign beat_in = '{data: s_wdata, strb: s_wstrb};

    lw_hold_slot #(.W(ADDR_W)) u_aw_slot (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (s_awvalid),
        .in_payload (s_awaddr),
        .fire       (fire),
        .ready      (s_awready),
        .have       (aw_have),
        .payload    (addr_sel)
    );

    lw_hold_slot #(.W(BEAT_W)) u_w_slot (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (s_wvalid),
        .in_payload (beat_in),
        .fire       (fire),
        .ready      (s_wready),
        .have       (w_have),
        .payload    (beat_sel)
    );

    lw_join_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .aw_have (aw_have),
        .w_have  (w_have),
        .b_ready (s_bready),
        .fire    (fire),
        .b_valid (s_bvalid)
    );

    lw_mem_port #(.ADDR_W(ADDR_W)) u_mem_port (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .addr   (addr_sel),
        .beat   (wbeat_t'(beat_sel)),
        .we     (mem_we),
        .addr_q (mem_addr),
        .data_q (mem_data),
        .be_q   (mem_be)
    );

    assign s_bresp = RESP_OKAY;

    // R2
    write_issue_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> mem_we);

    // R2
    no_spurious_write_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !mem_we);

    // R10
    both_full_chk: assert property (@(posedge clk) disable iff (rst)
        !s_bvalid |-> (s_awready || s_wready));

endmodule

// File: tb/lw_write_joiner_tb.sv
module lw_write_joiner_tb;

    localparam int AW    = 6;
    localparam int WORDS = 1 << (AW - 2);
    localparam int MAXOP = 512;

    // addr(6) data(32) strb(4) aw_gap(4) w_gap(4)
    localparam logic [49:0] TABLE [0:7] = '{
        {6'h04, 32'h11223344, 4'hF, 4'd0, 4'd0},
        {6'h08, 32'hA5A5A5A5, 4'h1, 4'd0, 4'd3},
        {6'h0C, 32'hDEADBEEF, 4'h6, 4'd3, 4'd0},
        {6'h04, 32'hCAFEF00D, 4'h8, 4'd1, 4'd2},
        {6'h10, 32'h01020304, 4'h0, 4'd2, 4'd1},
        {6'h3C, 32'hFFFFFFFF, 4'hA, 4'd0, 4'd4},
        {6'h08, 32'h55667788, 4'hE, 4'd4, 4'd0},
        {6'h3C, 32'h12345678, 4'h5, 4'd0, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        s_awvalid, s_awready;
    logic [AW-1:0] s_awaddr;
    logic        s_wvalid, s_wready;
    logic [31:0] s_wdata;
    logic [3:0]  s_wstrb;
    logic        s_bvalid, s_bready;
    logic [1:0]  s_bresp;
    logic        mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_be;

    always #4 clk = ~clk;

    lw_write_joiner #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
    );

    int checks = 0;
    int errors = 0;
    int n_ops = 0;
    int wr_seen = 0;
    int b_cnt = 0;
    int run = 0;
    int max_run = 0;
    bit done = 1'b0;
    bit rnd_stop = 1'b0;

    logic [AW-1:0] op_addr [0:MAXOP-1];
    logic [31:0]   op_data [0:MAXOP-1];
    logic [3:0]    op_strb [0:MAXOP-1];
    int            op_awg  [0:MAXOP-1];
    int            op_wg   [0:MAXOP-1];
    logic [31:0]   seen_mem [0:WORDS-1];
    logic [31:0]   ref_mem  [0:WORDS-1];
    logic          prev_stall = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_op(input logic [AW-1:0] a, input logic [31:0] d,
                           input logic [3:0] s, input int ag, input int wg);
        op_addr[n_ops] = a; op_data[n_ops] = d; op_strb[n_ops] = s;
        op_awg[n_ops] = ag; op_wg[n_ops] = wg;
        n_ops++;
    endtask

    task automatic drive_aw(input int first, input int last);
        for (int i = first; i <= last; i++) begin
            repeat (op_awg[i]) @(negedge clk);
            s_awvalid = 1'b1; s_awaddr = op_addr[i];
            while (!s_awready) @(negedge clk);
            @(negedge clk);
            s_awvalid = 1'b0;
        end
    endtask

    task automatic drive_w(input int first, input int last);
        for (int i = first; i <= last; i++) begin
            repeat (op_wg[i]) @(negedge clk);
            s_wvalid = 1'b1; s_wdata = op_data[i]; s_wstrb = op_strb[i];
            while (!s_wready) @(negedge clk);
            @(negedge clk);
            s_wvalid = 1'b0;
        end
    endtask

    task automatic run_ops(input int first, input int last);
        fork
            drive_aw(first, last);
            drive_w(first, last);
        join
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // port monitor: pairing, response code, response hold, throughput
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (wr_seen >= n_ops) chk("R12 unexpected write", 64'd1, 64'd0);
                else begin
                    chk("R3 addr", mem_addr, op_addr[wr_seen]);
                    chk("R3 data", mem_data, op_data[wr_seen]);
                    chk("R4 byte enables", mem_be, op_strb[wr_seen]);
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) seen_mem[mem_addr[AW-1:2]][8*b +: 8] = mem_data[8*b +: 8];
                end
                wr_seen++;
                run++;
                if (run > max_run) max_run = run;
            end else run = 0;
            if (prev_stall) chk("R5 response held", s_bvalid, 1'b1);
            if (s_bvalid) chk("R6 resp okay", s_bresp, 2'b00);
            if (s_bvalid && s_bready) b_cnt++;
            prev_stall = s_bvalid && !s_bready;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin seen_mem[i] = '0; ref_mem[i] = '0; end
        rst = 1'b1; s_awvalid = 0; s_wvalid = 0; s_bready = 0;
        s_awaddr = '0; s_wdata = '0; s_wstrb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk("R1 awready", s_awready, 1'b1);
        chk("R1 wready", s_wready, 1'b1);
        chk("R1 bvalid", s_bvalid, 1'b0);
        chk("R1 mem_we", mem_we, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 awready after release", s_awready, 1'b1);
        chk("R1 bvalid after release", s_bvalid, 1'b0);

        // table walk: skewed address-first and data-first pairs
        s_bready = 1'b1;
        for (int i = 0; i < 8; i++)
            push_op(TABLE[i][49:44], TABLE[i][43:12], TABLE[i][11:8],
                    int'(TABLE[i][7:4]), int'(TABLE[i][3:0]));
        run_ops(0, 7);
        repeat (4) @(negedge clk);
        chk("R12 table writes", wr_seen, 8);
        chk("R12 table responses", b_cnt, 8);

        // blocked response channel
        s_bready = 1'b0;
        push_op(6'h14, 32'h0BAD0001, 4'hF, 0, 0);
        s_awvalid = 1; s_awaddr = 6'h14; s_wvalid = 1; s_wdata = 32'h0BAD0001; s_wstrb = 4'hF;
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0;
        chk("R5 bvalid set with bready low", s_bvalid, 1'b1);
        chk("R8 awready after write", s_awready, 1'b1);
        chk("R8 wready after write", s_wready, 1'b1);
        push_op(6'h18, 32'h0BAD0002, 4'h3, 0, 0);
        s_awvalid = 1; s_awaddr = 6'h18;
        @(negedge clk);
        s_awvalid = 0;
        chk("R7 awready drops under stall", s_awready, 1'b0);
        chk("R8 wready idle stays high", s_wready, 1'b1);
        repeat (2) @(negedge clk);
        chk("R7 awready held low", s_awready, 1'b0);
        chk("R2 no write while blocked", wr_seen, 9);
        s_wvalid = 1; s_wdata = 32'h0BAD0002; s_wstrb = 4'h3;
        @(negedge clk);
        s_wvalid = 0;
        chk("R7 wready drops under stall", s_wready, 1'b0);
        chk("R10 both full only with bvalid", s_bvalid, 1'b1);
        s_bready = 1'b1;
        @(negedge clk);
        chk("R8 awready reopens", s_awready, 1'b1);
        chk("R8 wready reopens", s_wready, 1'b1);
        chk("R5 new response", s_bvalid, 1'b1);
        @(negedge clk);
        chk("R5 response retired", s_bvalid, 1'b0);

        // data first, no back-pressure
        push_op(6'h1C, 32'h600DD00D, 4'h9, 0, 0);
        s_wvalid = 1; s_wdata = 32'h600DD00D; s_wstrb = 4'h9;
        @(negedge clk);
        s_wvalid = 0;
        chk("R9 wready low awaiting address", s_wready, 1'b0);
        chk("R9 awready high", s_awready, 1'b1);
        repeat (2) @(negedge clk);
        chk("R9 still waiting", s_wready, 1'b0);
        chk("R2 no write without address", s_bvalid, 1'b0);
        s_awvalid = 1; s_awaddr = 6'h1C;
        @(negedge clk);
        s_awvalid = 0;
        chk("R9 write from held data", s_bvalid, 1'b1);
        chk("R8 wready after pairing", s_wready, 1'b1);
        repeat (3) @(negedge clk);

        // full-rate streaming
        max_run = 0;
        for (int i = 0; i < 8; i++)
            push_op(AW'(4 * i), 32'hF0000000 + i, 4'hF, 0, 0);
        run_ops(n_ops - 8, n_ops - 1);
        repeat (3) @(negedge clk);
        chk("R11 one write per clock", (max_run >= 8), 1'b1);

        // random skew and back-pressure
        for (int i = 0; i < 300; i++)
            push_op(AW'($urandom), $urandom, 4'($urandom), $urandom % 4, $urandom % 4);
        fork
            begin
                run_ops(n_ops - 300, n_ops - 1);
                rnd_stop = 1'b1;
            end
            begin
                while (!rnd_stop) begin
                    @(negedge clk);
                    s_bready = ($urandom % 3) != 0;
                end
            end
        join
        s_bready = 1'b1;
        repeat (10) @(negedge clk);

        // R12
        chk("R12 total writes", wr_seen, n_ops);
        chk("R12 total responses", b_cnt, n_ops);
        for (int i = 0; i < n_ops; i++)
            for (int b = 0; b < 4; b++)
                if (op_strb[i][b]) ref_mem[op_addr[i][AW-1:2]][8*b +: 8] = op_data[i][8*b +: 8];
        for (int w = 0; w < WORDS; w++)
            chk("R4 R12 memory word", seen_mem[w], ref_mem[w]);
        finish_run();
    end

endmodule